// File: doc/BRIEF.md
# Interrupt Cause Register Unit

This unit collects interrupt causes from a memory management controller and drives one level-sensitive interrupt line to the system. Each cause arrives as a one-cycle event pulse and is latched in a pending register. Software sees these bits through a small register port with separate read and write strobes. It acknowledges causes with a write-one-to-clear register. It chooses which causes reach the line through an enable register, and it reads the enabled causes back through a status register.

Software can also write the pending register directly to make causes pending on purpose. This lets the driver check that the interrupt line is wired to the right place before it relies on it. The line stays asserted for as long as any enabled cause is pending.

Top module: `irq_cause_regs`

## Requirements
- R1: After reset the pending and enable registers are zero, `irq_o` is low and `rd_data_o` is zero.
- R2: Word addresses select the registers as follows: 0 is pending, 1 is clear, 2 is enable, 3 is status. Any other address reads as zero and ignores writes. The clear register reads as zero. In the default two-cause configuration, bit 0 is the page fault cause and bit 1 is the read bus error cause.
- R3: An event pulse on `evt_i[n]` sets pending bit n at the next clock edge. Several causes may be pending at the same time.
- R4: Reading the pending register returns every pending cause, whatever the enable register holds.
- R5: A write to the pending register sets each bit written as 1. Bits written as 0 keep their value.
- R6: A write to the clear register clears each pending bit written as 1. Bits written as 0 are not affected.
- R7: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: The enable register can be read and written. It changes only when it is written, and it reads back the value last written.
- R9: The status register reads as pending AND enable. Writes to it have no effect.
- R10: `irq_o` is the OR of the status bits. It follows the registers with no added cycle and stays high until the causes are cleared or disabled.
- R11: `rd_data_o` is registered. It shows the addressed register after the clock edge that samples `rd_en_i`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | One-cycle cause event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | NUM_SRC | Write data, one bit per cause |
| rd_data_o | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Level interrupt line |

## Verification
Some properties are checked on every cycle:
- a pulse always leaves its pending bit set in the following cycle;
- a clear without a competing pulse always drops the bit;
- a pending bit never rises unless a pulse or a set-write caused it;
- the enable register and the read data hold unless they are addressed;
- the line stays low whenever every cause is disabled.

Other behaviour can only be shown by the bench's scenarios. These are the address map, the exact values of set-writes and clear-writes across every combination of pending, clear and enable patterns, the tie between a pulse and a clear, and the writes that must be ignored.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  // Word offsets of the register set
  localparam int unsigned OFS_PEND = 0;
  localparam int unsigned OFS_CLR  = 1;
  localparam int unsigned OFS_EN   = 2;
  localparam int unsigned OFS_STAT = 3;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_PEND = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_EN   = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              set_we_o,
  output logic              clr_we_o,
  output logic              en_we_o
);

  function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    if (32'(a) == OFS_PEND)      s = SEL_PEND;
    else if (32'(a) == OFS_CLR)  s = SEL_CLR;
    else if (32'(a) == OFS_EN)   s = SEL_EN;
    else if (32'(a) == OFS_STAT) s = SEL_STAT;
    else                         s = SEL_NONE;
    return s;
  endfunction

  assign sel_o    = addr_to_sel(addr_i);
  assign set_we_o = wr_en_i && (sel_o == SEL_PEND);
  assign clr_we_o = wr_en_i && (sel_o == SEL_CLR);
  assign en_we_o  = wr_en_i && (sel_o == SEL_EN);

  // R2: at most one register is written per cycle
  always_comb begin
    one_target_chk: assert ($countones({set_we_o, clr_we_o, en_we_o}) <= 1);
  end

endmodule

// File: rtl/irq_pending_bits.sv
module irq_pending_bits #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] wr_bits_i,
  output logic [NUM_SRC-1:0] pend_o
);

  // Next value of one cause: an event or a set-write wins over a clear.
  function automatic logic next_bit(input logic cur, input logic evt,
                                    input logic set, input logic clr);
    return evt | set | (cur & ~clr);
  endfunction

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic set_w;
    logic clr_w;
    logic pend_q;

    assign set_w = set_we_i & wr_bits_i[g];
    assign clr_w = clr_we_i & wr_bits_i[g];

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= next_bit(pend_q, evt_i[g], set_w, clr_w);
    end

    assign pend_o[g] = pend_q;

    // R3
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> pend_o[g]);

    // R6
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && wr_bits_i[g] && !evt_i[g]) |=> !pend_o[g]);

    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o[g]) |-> $past(evt_i[g] || (set_we_i && wr_bits_i[g])));
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wr_bits_i,
  output logic [NUM_SRC-1:0] en_o
);

  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= '0;
    else if (we_i) en_q <= wr_bits_i;
  end

  assign en_o = en_q;

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_o));

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_cause_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en_i,
  input  reg_sel_e           sel_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic [NUM_SRC-1:0] rd_data_o
);

  logic [NUM_SRC-1:0] rd_mux;
  logic [NUM_SRC-1:0] rd_q;

  always_comb begin
    unique case (sel_i)
      SEL_PEND: rd_mux = pend_i;
      SEL_EN:   rd_mux = en_i;
      SEL_STAT: rd_mux = stat_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_cause_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_o
);

  reg_sel_e           sel_w;
  logic               set_we_w;
  logic               clr_we_w;
  logic               en_we_w;
  logic [NUM_SRC-1:0] pend_w;
  logic [NUM_SRC-1:0] en_w;
  logic [NUM_SRC-1:0] stat_w;

  function automatic logic [NUM_SRC-1:0] gate(input logic [NUM_SRC-1:0] p,
                                              input logic [NUM_SRC-1:0] e);
    return p & e;
  endfunction

  irq_addr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .sel_o    (sel_w),
    .set_we_o (set_we_w),
    .clr_we_o (clr_we_w),
    .en_we_o  (en_we_w)
  );

  irq_pending_bits #(.NUM_SRC(NUM_SRC)) i_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .set_we_i  (set_we_w),
    .clr_we_i  (clr_we_w),
    .wr_bits_i (wr_data_i),
    .pend_o    (pend_w)
  );

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) i_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (en_we_w),
    .wr_bits_i (wr_data_i),
    .en_o      (en_w)
  );

  assign stat_w = gate(pend_w, en_w);
  assign irq_o  = |stat_w;

  irq_read_port #(.NUM_SRC(NUM_SRC)) i_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .sel_i     (sel_w),
    .pend_i    (pend_w),
    .en_i      (en_w),
    .stat_i    (stat_w),
    .rd_data_o (rd_data_o)
  );

  // R10
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w == '0) |-> !irq_o);

  // R9
  stat_within_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w & ~pend_w) == '0);

endmodule

// File: tb/test_irq_cause_regs.sv
module test_irq_cause_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] evt = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [1:0] wdata = '0;
  logic [1:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_cause_regs i_irq_cause_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [1:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] v;
    repeat (3) @(negedge clk);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    do_read(3'd0, v); check("R1 pending", int'(v), 0);
    do_read(3'd2, v); check("R1 enable", int'(v), 0);

    // R4 R5 R8 R9 R10: every pending x enable pattern
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        do_write(3'd1, 2'b11);
        do_write(3'd0, 2'(p));
        do_write(3'd2, 2'(m));
        check("R10 irq", int'(irq), int'((p & m) != 0));
        do_read(3'd0, v); check("R4 pending", int'(v), p);
        do_read(3'd2, v); check("R8 enable", int'(v), m);
        do_read(3'd3, v); check("R9 status", int'(v), p & m);
      end
    end

    // R5 R6: set-write ORs, clear-write removes ones only
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        do_write(3'd1, 2'b11);
        do_write(3'd0, 2'(p));
        do_write(3'd0, 2'(c));
        do_read(3'd0, v); check("R5 set or", int'(v), p | c);
        do_write(3'd1, 2'b11);
        do_write(3'd0, 2'(p));
        do_write(3'd1, 2'(c));
        do_read(3'd0, v); check("R6 clear", int'(v), p & ~c & 3);
      end
    end

    // R3: both events at once, then line held
    do_write(3'd1, 2'b11);
    do_write(3'd2, 2'b01);
    @(negedge clk); evt = 2'b11;
    @(negedge clk); evt = 2'b00;
    check("R3 irq after event", int'(irq), 1);
    repeat (5) @(negedge clk);
    check("R10 level held", int'(irq), 1);
    do_read(3'd0, v); check("R3 both pending", int'(v), 3);
    do_write(3'd2, 2'b00);
    check("R10 masked off", int'(irq), 0);
    do_write(3'd2, 2'b10);
    check("R10 reenable one", int'(irq), 1);
    do_write(3'd1, 2'b10);
    check("R10 cleared", int'(irq), 0);

    // R7: event and clear of bit 0 in the same cycle
    do_write(3'd1, 2'b11);
    @(negedge clk);
    evt = 2'b01; wr_en = 1'b1; addr = 3'd1; wdata = 2'b11;
    @(negedge clk);
    evt = 2'b00; wr_en = 1'b0;
    do_read(3'd0, v); check("R7 event wins", int'(v), 1);

    // R9: status write ignored
    do_write(3'd1, 2'b11);
    do_write(3'd2, 2'b01);
    do_write(3'd3, 2'b11);
    do_read(3'd0, v); check("R9 status write pending", int'(v), 0);
    do_read(3'd2, v); check("R9 status write enable", int'(v), 1);

    // R2: unmapped addresses and clear readback
    for (int a = 4; a < 8; a++) begin
      do_write(3'(a), 2'b11);
      do_read(3'(a), v); check("R2 unmapped read", int'(v), 0);
    end
    do_read(3'd0, v); check("R2 unmapped no pend", int'(v), 0);
    do_read(3'd2, v); check("R2 unmapped no enable", int'(v), 1);
    do_write(3'd0, 2'b10);
    do_read(3'd1, v); check("R2 clear reads zero", int'(v), 0);

    // R11: read data held while no read
    do_read(3'd0, v);
    do_write(3'd1, 2'b11);
    repeat (3) @(negedge clk);
    check("R11 held", int'(rd_data), 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule